// File: doc/BRIEF.md
# Packed Lane Permutation Unit

This unit rearranges the lanes of two 64-bit operands, A and B, under an operation code. It interleaves lanes taken from the low or high halves of both operands. It separates the even or odd lanes of both operands. It widens four bytes or two halfwords of A, with zero or sign extension. It narrows both operands into one with saturation. It reorders the bytes of A under a pattern held in B. It also cuts an 8-byte window out of the 128-bit value formed by A above B. Lanes are numbered from the least significant end. Lane 0 of a w-bit view sits in bits [w-1:0].

The permutation network is pure combinational logic, followed by one register stage. A request is presented with `in_valid`. Its result, together with `out_valid` and an error flag, appears one clock later. The error flag marks a shuffle index outside 0..7, an align count above 7, or an unassigned code. In that case the result is still computed from the masked low bits of the index or count.

Top module: `lane_perm_unit`

## Requirements
- R1: On the clock edge where `in_valid` is 1, `result` and `illegal` load the outcome of `op`, `a`, `b` and `win_cnt`. On every edge `out_valid` takes the value of `in_valid`. An active-low reset clears `out_valid`, `result` and `illegal` to 0.
- R2: On an edge where `in_valid` is 0, `result` and `illegal` keep their values.
- R3: Codes 0..5 interleave lanes. In order these are low and high at 8 bits, low and high at 16 bits, and low and high at 32 bits. With n lanes and half offset h (0 for low, n/2 for high), output lane 2i+1 is A lane i+h and output lane 2i is B lane i+h, for i < n/2.
- R4: Codes 6..11 de-interleave lanes. In order these are even and odd at 8 bits, even and odd at 16 bits, and even and odd at 32 bits. With p = 0 for even and p = 1 for odd, output lane i is B lane 2i+p and output lane i+n/2 is A lane 2i+p.
- R5: Codes 12..19 widen A; B is unused. The codes are, in order: low bytes zero-extended, high bytes zero-extended, low bytes sign-extended, high bytes sign-extended. The next four codes do the same for halfwords into 32-bit lanes. Output lane i comes from A lane i (low) or lane i+n/2 (high) of the narrow view.
- R6: Code 20 narrows signed 32-bit lanes to 16 bits, clamped to -32768..32767. Code 21 does the same with the range 0..65535. Output lanes 0..1 come from B lanes 0..1 and lanes 2..3 from A lanes 0..1.
- R7: Code 22 narrows signed 16-bit lanes to bytes, clamped to 0..255. Code 23 does the same with the range -128..127. Output bytes 0..3 come from B and bytes 4..7 from A.
- R8: Code 24 sets output byte c to A byte (B byte c bits [2:0]). `illegal` is 1 exactly when any B byte has a bit set in [7:3].
- R9: Code 25 with count c = `win_cnt[2:0]` returns B when c is 0, and otherwise (B >> 8c) | (A << (64-8c)). `illegal` is 1 exactly when `win_cnt` exceeds 7.
- R10: Codes 26..31 return a zero result with `illegal` set to 1. For codes 0..23, `illegal` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| op | input | 5 | Operation code |
| a | input | 64 | Operand A |
| b | input | 64 | Operand B, or the shuffle pattern |
| win_cnt | input | 4 | Align byte count |
| out_valid | output | 1 | Result register holds a new result |
| result | output | 64 | Registered result |
| illegal | output | 1 | Registered error flag |

## Verification
The checker watches on every cycle the one-cycle valid timing, the holding of the result when no request arrives, the align count 0 pass-through, the 32-bit interleave and the align-count error flag. The lane mapping of each code, the saturation limits of the narrowing codes, and the shuffle index masking only show up in the bench scenarios. Those scenarios compare each result with a lane-by-lane model, over random operands and chosen edges such as clamp boundaries and illegal patterns.

// File: rtl/lane_perm_unit.sv
module lane_perm_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [4:0]  op,
  input  logic [63:0] a,
  input  logic [63:0] b,
  input  logic [3:0]  win_cnt,
  output logic        out_valid,
  output logic [63:0] result,
  output logic        illegal
);

  function automatic logic [63:0] f_zip(input logic [63:0] x, input logic [63:0] y,
                                        input int w, input logic hi);
    logic [63:0] r;
    int l, k, s;
    r = '0;
    for (int j = 0; j < 64; j++) begin
      l = j / w;
      k = j % w;
      s = l / 2 + (hi ? (64 / w) / 2 : 0);
      r[j] = l[0] ? x[s*w+k] : y[s*w+k];
    end
    return r;
  endfunction

  function automatic logic [63:0] f_unzip(input logic [63:0] x, input logic [63:0] y,
                                          input int w, input logic odd);
    logic [63:0] r;
    int l, k, h;
    r = '0;
    h = (64 / w) / 2;
    for (int j = 0; j < 64; j++) begin
      l = j / w;
      k = j % w;
      if (l >= h) r[j] = x[(2*(l-h) + int'(odd))*w + k];
      else        r[j] = y[(2*l + int'(odd))*w + k];
    end
    return r;
  endfunction

  function automatic logic [63:0] f_widen(input logic [63:0] x, input int w,
                                          input logic hi, input logic sgn);
    logic [63:0] r;
    int l, k, s;
    r = '0;
    for (int j = 0; j < 64; j++) begin
      l = j / (2*w);
      k = j % (2*w);
      s = l + (hi ? 32 / w : 0);
      r[j] = (k < w) ? x[s*w+k] : (sgn & x[s*w+w-1]);
    end
    return r;
  endfunction

  logic [63:0] pk32, pk16, shuf, win, nxt;
  logic        bad_pat, nxt_ill;
  logic [2:0]  cnt;

  assign cnt = win_cnt[2:0];

  always_comb begin
    logic [63:0] src;
    logic signed [31:0] v;
    pk32 = '0;
    for (int i = 0; i < 4; i++) begin
      src = i[1] ? a : b;
      v = $signed(src[(i%2)*32 +: 32]);
      if (op[0]) begin
        if (v < 0)              pk32[i*16 +: 16] = 16'h0000;
        else if (v > 32'sd65535) pk32[i*16 +: 16] = 16'hffff;
        else                    pk32[i*16 +: 16] = v[15:0];
      end else begin
        if (v < -32'sd32768)    pk32[i*16 +: 16] = 16'h8000;
        else if (v > 32'sd32767) pk32[i*16 +: 16] = 16'h7fff;
        else                    pk32[i*16 +: 16] = v[15:0];
      end
    end
  end

  always_comb begin
    logic [63:0] src;
    logic signed [15:0] v;
    pk16 = '0;
    for (int i = 0; i < 8; i++) begin
      src = i[2] ? a : b;
      v = $signed(src[(i%4)*16 +: 16]);
      if (!op[0]) begin
        if (v < 0)              pk16[i*8 +: 8] = 8'h00;
        else if (v > 16'sd255)  pk16[i*8 +: 8] = 8'hff;
        else                    pk16[i*8 +: 8] = v[7:0];
      end else begin
        if (v < -16'sd128)      pk16[i*8 +: 8] = 8'h80;
        else if (v > 16'sd127)  pk16[i*8 +: 8] = 8'h7f;
        else                    pk16[i*8 +: 8] = v[7:0];
      end
    end
  end

  always_comb begin
    shuf = '0;
    bad_pat = 1'b0;
    for (int c = 0; c < 8; c++) begin
      shuf[c*8 +: 8] = a[int'(b[c*8 +: 3])*8 +: 8];
      bad_pat = bad_pat | (|b[c*8+3 +: 5]);
    end
  end

  assign win = (cnt == 3'd0) ? b
             : ((b >> {cnt, 3'b000}) | (a << (7'd64 - {1'b0, cnt, 3'b000})));

  always_comb begin
    nxt = '0;
    nxt_ill = 1'b0;
    case (op)
      5'd0, 5'd1:   nxt = f_zip(a, b, 8,  op[0]);
      5'd2, 5'd3:   nxt = f_zip(a, b, 16, op[0]);
      5'd4, 5'd5:   nxt = f_zip(a, b, 32, op[0]);
      5'd6, 5'd7:   nxt = f_unzip(a, b, 8,  op[0]);
      5'd8, 5'd9:   nxt = f_unzip(a, b, 16, op[0]);
      5'd10, 5'd11: nxt = f_unzip(a, b, 32, op[0]);
      5'd12, 5'd13, 5'd14, 5'd15: nxt = f_widen(a, 8,  op[0], op[1]);
      5'd16, 5'd17, 5'd18, 5'd19: nxt = f_widen(a, 16, op[0], op[1]);
      5'd20, 5'd21: nxt = pk32;
      5'd22, 5'd23: nxt = pk16;
      5'd24: begin nxt = shuf; nxt_ill = bad_pat;    end
      5'd25: begin nxt = win;  nxt_ill = win_cnt[3]; end
      default: nxt_ill = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= nxt;
        illegal <= nxt_ill;
      end
    end
  end

endmodule

// File: rtl/lane_perm_chk.sv
module lane_perm_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [4:0]  op,
  input logic [63:0] a,
  input logic [63:0] b,
  input logic [3:0]  win_cnt,
  input logic        out_valid,
  input logic [63:0] result,
  input logic        illegal
);

  p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_valid_drops_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(illegal)));

  p_zip32_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 5'd4) |=> result == {$past(a[31:0]), $past(b[31:0])});

  p_align_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 5'd25 && win_cnt == 4'd0) |=> result == $past(b));

  p_align_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 5'd25) |=> illegal == $past(win_cnt > 4'd7));

  p_unused_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op > 5'd25) |=> (illegal && result == 64'd0));

endmodule

bind lane_perm_unit lane_perm_chk u_chk (.*);

// File: tb/sim_lane_perm_unit.sv
module sim_lane_perm_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [4:0]  op = '0;
  logic [63:0] a = '0, b = '0;
  logic [3:0]  win_cnt = '0;
  logic        out_valid, illegal;
  logic [63:0] result;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_perm_unit u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .a(a), .b(b),
                     .win_cnt(win_cnt), .out_valid(out_valid), .result(result), .illegal(illegal));

  function automatic logic [63:0] lane(input logic [63:0] v, input int w, input int i);
    return (v >> (i*w)) & ((64'd1 << w) - 64'd1);
  endfunction

  function automatic logic [63:0] place(input logic [63:0] x, input int w, input int i);
    return (x & ((64'd1 << w) - 64'd1)) << (i*w);
  endfunction

  function automatic longint as_signed(input logic [63:0] x, input int w);
    longint t = longint'(x);
    if (x[w-1]) t = t - (longint'(1) << w);
    return t;
  endfunction

  function automatic longint clampv(input longint v, input longint lo, input longint hi);
    return (v < lo) ? lo : (v > hi) ? hi : v;
  endfunction

  function automatic logic [63:0] model(input int code, input logic [63:0] x,
                                        input logic [63:0] y, input logic [3:0] c4);
    logic [63:0] r = '0;
    int w, n, sel;
    if (code <= 5) begin
      w = 8 << (code / 2); n = 64 / w; sel = (code % 2) ? n/2 : 0;
      for (int i = 0; i < n/2; i++) begin
        r |= place(lane(y, w, i+sel), w, 2*i);
        r |= place(lane(x, w, i+sel), w, 2*i+1);
      end
    end else if (code <= 11) begin
      w = 8 << ((code-6) / 2); n = 64 / w; sel = code % 2;
      for (int i = 0; i < n/2; i++) begin
        r |= place(lane(y, w, 2*i+sel), w, i);
        r |= place(lane(x, w, 2*i+sel), w, i+n/2);
      end
    end else if (code <= 19) begin
      w = (code <= 15) ? 8 : 16; n = 32 / w;
      sel = (code % 2) ? n : 0;
      for (int i = 0; i < n; i++) begin
        longint e;
        e = ((code % 4) >= 2) ? as_signed(lane(x, w, i+sel), w) : longint'(lane(x, w, i+sel));
        r |= place(64'(e), 2*w, i);
      end
    end else if (code <= 21) begin
      for (int i = 0; i < 4; i++) begin
        longint e = as_signed(lane(i < 2 ? y : x, 32, i % 2), 32);
        e = (code == 20) ? clampv(e, -32768, 32767) : clampv(e, 0, 65535);
        r |= place(64'(e), 16, i);
      end
    end else if (code <= 23) begin
      for (int i = 0; i < 8; i++) begin
        longint e = as_signed(lane(i < 4 ? y : x, 16, i % 4), 16);
        e = (code == 22) ? clampv(e, 0, 255) : clampv(e, -128, 127);
        r |= place(64'(e), 8, i);
      end
    end else if (code == 24) begin
      for (int i = 0; i < 8; i++) r |= place(lane(x, 8, int'(lane(y, 8, i) % 8)), 8, i);
    end else if (code == 25) begin
      int cc = int'(c4) % 8;
      r = (cc == 0) ? y : ((y >> (8*cc)) | (x << (64 - 8*cc)));
    end
    return r;
  endfunction

  function automatic logic model_ill(input int code, input logic [63:0] y, input logic [3:0] c4);
    logic f = 1'b0;
    if (code > 25) f = 1'b1;
    if (code == 24) for (int i = 0; i < 8; i++) if (lane(y, 8, i) > 7) f = 1'b1;
    if (code == 25) f = (c4 > 4'd7);
    return f;
  endfunction

  function automatic string tag(input int code);
    if (code <= 5)  return "R3";
    if (code <= 11) return "R4";
    if (code <= 19) return "R5";
    if (code <= 21) return "R6";
    if (code <= 23) return "R7";
    if (code == 24) return "R8";
    if (code == 25) return "R9";
    return "R10";
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic run_op(input int code, input logic [63:0] x, input logic [63:0] y,
                        input logic [3:0] c4);
    @(negedge clk);
    in_valid = 1'b1; op = 5'(code); a = x; b = y; win_cnt = c4;
    @(negedge clk);
    in_valid = 1'b0;
    check("R1", {63'd0, out_valid}, 64'd1);
    check(tag(code), result, model(code, x, y, c4));
    check(code > 23 ? tag(code) : "R10", {63'd0, illegal}, {63'd0, model_ill(code, y, c4)});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [63:0] keep;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1", {out_valid, illegal}, 64'd0);
    check("R1", result, 64'd0);
    rst_n = 1'b1;

    run_op(0, 64'h0706050403020100, 64'h1716151413121110, 4'd0);
    run_op(5, 64'hAAAAAAAA_BBBBBBBB, 64'hCCCCCCCC_DDDDDDDD, 4'd0);
    run_op(7, 64'h0706050403020100, 64'h1716151413121110, 4'd0);
    run_op(14, 64'h00000000_80FF7F01, 64'd0, 4'd0);
    run_op(19, 64'h8000FFFF_00000000, 64'd0, 4'd0);
    run_op(20, 64'h00007FFF_FFFF8000, 64'h00008000_FFFF7FFF, 4'd0);
    run_op(21, 64'h00010000_FFFFFFFF, 64'h0000FFFF_00000000, 4'd0);
    run_op(22, 64'h0100_00FF_FFFF_0000, 64'h0080_8000_7FFF_0001, 4'd0);
    run_op(23, 64'h0080_007F_FF7F_FF80, 64'h0100_FE00_0000_8000, 4'd0);
    run_op(24, 64'h8877665544332211, 64'h0001020304050607, 4'd0);
    run_op(24, 64'h8877665544332211, 64'h0001020304050F07, 4'd0);
    run_op(25, 64'h1111111111111111, 64'h2222222222222222, 4'd0);
    run_op(25, 64'h0706050403020100, 64'h0F0E0D0C0B0A0908, 4'd3);
    run_op(25, 64'h0706050403020100, 64'h0F0E0D0C0B0A0908, 4'd7);
    run_op(25, 64'h0706050403020100, 64'h0F0E0D0C0B0A0908, 4'd9);
    run_op(27, 64'hFFFFFFFFFFFFFFFF, 64'h1, 4'd0);

    keep = result;
    @(negedge clk);
    op = 5'd0; a = '1; b = '1;
    @(negedge clk);
    check("R2", result, keep);
    check("R2", {63'd0, out_valid}, 64'd0);

    for (int t = 0; t < 1500; t++) begin
      int code;
      logic [63:0] x, y;
      logic [3:0] c4;
      code = int'($urandom_range(31, 0));
      x = {$urandom(), $urandom()};
      y = {$urandom(), $urandom()};
      c4 = 4'($urandom_range(15, 0));
      if (code == 24 && ($urandom_range(3, 0) != 0)) y = y & 64'h0707070707070707;
      if (code == 25 && ($urandom_range(3, 0) != 0)) c4[3] = 1'b0;
      run_op(code, x, y, c4);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule